// File: doc/BRIEF.md
# Port-Addressed Byte Memory

This block gives a small controller that has no data-memory bus a 256-byte scratch store reached entirely through its I/O space. The controller reaches memory in two steps. It first writes a byte address to an address port. It then reads or writes the data port, and that access goes to the location held in the address latch.

The block watches a 4-bit device select. Code zero means no device is selected, so 15 codes remain usable. The block answers on two of these codes, set by parameters. Write and read strobes qualify the select. A read returns data in the same I/O cycle, through combinational logic, and raises a drive enable so that the controller's input bus can be multiplexed. The address latch keeps its value between accesses. A run of data-port accesses therefore works on one location until a new address is written. Reset clears the latch and leaves the stored bytes alone.

Top module: `iomem_ram`

## Requirements
- R1: A write strobe with select equal to ADDR_PORT (default 4) loads wdata_i into the address latch at the next rising clock edge. A read strobe on ADDR_PORT returns the latched address on rdata_o in the same cycle.
- R2: While rst_ni is low, the address latch is zero, with no clock edge needed. A read of ADDR_PORT during reset returns 0.
- R3: A write strobe with select equal to DATA_PORT (default 5) stores wdata_i at the latched address on the next rising clock edge.
- R4: A read strobe on DATA_PORT presents the byte stored at the latched address on rdata_o in the same cycle.
- R5: The address latch keeps its value through data-port reads and writes. It does not increment.
- R6: A strobe whose select is neither ADDR_PORT nor DATA_PORT, including code 0, changes neither the latch nor the memory. During such a strobe rdata_o is 0 and rd_en_o is low.
- R7: A reset leaves the memory contents unchanged.
- R8: rd_en_o is high exactly when io_rd_i is high and the select is ADDR_PORT or DATA_PORT. Whenever rd_en_o is low, rdata_o is 0.
- R9: Read strobes change neither the memory nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the address latch only |
| dev_sel_i | input | 4 | Device select code, 0 = none |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| wdata_i | input | 8 | Byte from the controller |
| rdata_o | output | 8 | Byte to the controller, 0 when not driving |
| rd_en_o | output | 1 | High while this block answers a read |

## Verification
The assertions assume that io_wr_i and io_rd_i are never high in the same cycle. They also assume that the select and the write data stay steady from one falling edge to the next while a strobe is high. The bench drives every access from a falling edge and sets the select, both strobes and the data together each time, so only one strobe is ever active. The stimulus sweeps all 256 addresses and every select code outside the two ports. It applies reset asynchronously between clock edges.

// File: rtl/iomem_pkg.sv
package iomem_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_ADDR = 2'd1,
    HIT_DATA = 2'd2
  } port_hit_e;
endpackage

// File: rtl/iomem_port_decode.sv
module iomem_port_decode
  import iomem_pkg::*;
#(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_PORT = 4,
  parameter int unsigned DATA_PORT = 5
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output port_hit_e        hit_o,
  output logic             addr_ld_o,
  output logic             data_we_o,
  output logic             rd_en_o
);
  localparam logic [SEL_W-1:0] ADDR_CODE = SEL_W'(ADDR_PORT);
  localparam logic [SEL_W-1:0] DATA_CODE = SEL_W'(DATA_PORT);

  always_comb begin
    hit_o = HIT_NONE;
    if (sel_i == ADDR_CODE)      hit_o = HIT_ADDR;
    else if (sel_i == DATA_CODE) hit_o = HIT_DATA;
  end

  assign addr_ld_o = wr_i && (hit_o == HIT_ADDR);
  assign data_we_o = wr_i && (hit_o == HIT_DATA);
  assign rd_en_o   = rd_i && (hit_o != HIT_NONE);
endmodule

// File: rtl/iomem_addr_latch.sv
module iomem_addr_latch #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));

  assert_reset_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (q_o == '0));
endmodule

// File: rtl/iomem_byte_store.sv
module iomem_byte_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset on storage: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[addr_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (!$stable(addr_i) || (rd_data_o == $past(wr_data_i))));

  assert_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (!$stable(addr_i) || $stable(rd_data_o)));
endmodule

// File: rtl/iomem_ram.sv
module iomem_ram
  import iomem_pkg::*;
#(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_PORT = 4,
  parameter int unsigned DATA_PORT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_en_o
);
  localparam logic [SEL_W-1:0] ADDR_CODE = SEL_W'(ADDR_PORT);
  localparam logic [SEL_W-1:0] DATA_CODE = SEL_W'(DATA_PORT);

  port_hit_e         hit;
  logic              addr_ld, data_we, rd_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mem_rd;

  iomem_port_decode #(
    .SEL_W(SEL_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_decode (
    .sel_i(dev_sel_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .hit_o(hit), .addr_ld_o(addr_ld), .data_we_o(data_we), .rd_en_o(rd_en)
  );

  iomem_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(addr_ld),
    .d_i(wdata_i[ADDR_W-1:0]), .q_o(addr_q)
  );

  iomem_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(data_we), .addr_i(addr_q),
    .wr_data_i(wdata_i), .rd_data_o(mem_rd)
  );

  // read mux: bus is zero unless this block drives it
  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (hit == HIT_ADDR) rdata_o[ADDR_W-1:0] = addr_q;
      else                 rdata_o = mem_rd;
    end
  end
  assign rd_en_o = rd_en;

  assert_foreign_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_i != ADDR_CODE && dev_sel_i != DATA_CODE) |-> (!rd_en_o && rdata_o == '0));

  assert_foreign_keeps_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_i != ADDR_CODE) |=> $stable(addr_q));

  assert_rden_needs_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> io_rd_i);

  assert_idle_bus_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |-> (rdata_o == '0));

  assert_data_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && dev_sel_i == DATA_CODE) |-> (rd_en_o && rdata_o == mem_rd));
endmodule

// File: tb/iomem_ram_tb.sv
`timescale 1ns/1ps
module iomem_ram_tb;
  localparam logic [3:0] PA = 4'd4;
  localparam logic [3:0] PD = 4'd5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       rd_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iomem_ram u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dev_sel_i(sel), .io_wr_i(wr), .io_rd_i(rd),
    .wdata_i(wd), .rdata_o(rdata), .rd_en_o(rd_en)
  );

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 11 + 5) ^ (a >> 3));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr = 1'b1; rd = 1'b0; wd = d;
  endtask

  task automatic io_rd(input logic [3:0] s, output logic [7:0] d, output logic en);
    @(negedge clk);
    sel = s; wr = 1'b0; rd = 1'b1; wd = 8'h00;
    #1;
    d = rdata; en = rd_en;
  endtask

  task automatic idle();
    @(negedge clk);
    sel = '0; wr = 1'b0; rd = 1'b0; wd = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic en;
    #1;
    // R2: latch is zero during reset, before any edge
    sel = PA; rd = 1'b1; #1;
    chk("R2 addr in reset", rdata, 8'h00);
    chk("R8 rd_en addr read", {7'b0, rd_en}, 8'h01);
    rd = 1'b0; sel = '0; #1;
    chk("R8 idle rd_en", {7'b0, rd_en}, 8'h00);
    chk("R8 idle bus", rdata, 8'h00);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1/R3: fill every location
    for (int a = 0; a < 256; a++) begin
      io_wr(PA, 8'(a));
      io_wr(PD, pat(a, 1));
    end
    // R1/R4: read back every location plus the latch
    for (int a = 0; a < 256; a++) begin
      io_wr(PA, 8'(a));
      io_rd(PA, d, en);
      chk("R1 addr readback", d, 8'(a));
      io_rd(PD, d, en);
      chk("R4 data read", d, pat(a, 1));
      chk("R8 rd_en data", {7'b0, en}, 8'h01);
    end

    // R5: latch holds across data accesses
    io_wr(PA, 8'h3c);
    io_wr(PD, 8'ha5);
    io_rd(PD, d, en); chk("R5 first write", d, 8'ha5);
    io_wr(PD, 8'h5a);
    io_rd(PD, d, en); chk("R5 overwrite same loc", d, 8'h5a);
    io_rd(PA, d, en); chk("R5 latch unchanged", d, 8'h3c);
    io_wr(PA, 8'h3d);
    io_rd(PD, d, en); chk("R5 neighbour untouched", d, pat(8'h3d, 1));

    // R6: every foreign code, write and read
    io_wr(PA, 8'h20);
    for (int s = 0; s < 16; s++) begin
      if (4'(s) == PA || 4'(s) == PD) continue;
      io_wr(4'(s), 8'hff);
      io_rd(4'(s), d, en);
      chk("R6 foreign read bus", d, 8'h00);
      chk("R6 foreign read rd_en", {7'b0, en}, 8'h00);
      io_rd(PA, d, en); chk("R6 latch kept", d, 8'h20);
      io_rd(PD, d, en); chk("R6 memory kept", d, pat(8'h20, 1));
    end

    // R9: repeated reads leave state alone
    io_wr(PA, 8'h77);
    for (int i = 0; i < 4; i++) begin
      io_rd(PD, d, en); chk("R9 repeated read", d, pat(8'h77, 1));
    end
    io_rd(PA, d, en); chk("R9 latch after reads", d, 8'h77);

    // R2/R7: asynchronous reset mid-run
    io_wr(PA, 8'hc8);
    idle();
    #1 rst_ni = 1'b0;
    #1;
    sel = PA; rd = 1'b1; #0.2;
    chk("R2 async clear", rdata, 8'h00);
    rd = 1'b0; sel = '0;
    @(negedge clk); rst_ni = 1'b1;
    io_rd(PD, d, en); chk("R7 loc 0 survives", d, pat(0, 1));
    io_wr(PA, 8'h3c);
    io_rd(PD, d, en); chk("R7 loc 3c survives", d, 8'h5a);
    io_wr(PA, 8'hc8);
    io_rd(PD, d, en); chk("R7 loc c8 survives", d, pat(8'hc8, 1));
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule